// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Protocol Engine

This block is the byte-level protocol engine of a serial EEPROM that sits on an I2C bus. It oversamples SCL and SDA with the system clock and detects Start, repeated Start and Stop conditions. It collects a select byte and checks the select byte's type nibble and chip-enable field against three strap inputs. On a match it pulls SDA low in the ninth bit slot. After a write select it takes a two-byte memory address, high byte first. Each following data byte goes out as a one-cycle strobe to an external page write controller. A Stop in the slot right after a data byte's acknowledge tells that controller to start its internal write cycle.

Reads fetch bytes from a synchronous memory array with one cycle of latency, into a one-byte buffer. Each byte goes onto SDA most significant bit first. The engine keeps sending while the master acknowledges. While the write controller reports an internal write cycle in progress, the engine drops all bus traffic.

The state machine has eleven states. ST_IDLE waits for a Start. ST_DEVSEL shifts in the select byte. ST_ACK_DEV acknowledges it, then goes to ST_TXDATA for a read or ST_ADDR_HI for a write. ST_ADDR_HI is followed by ST_ACK_AHI, then ST_ADDR_LO, then ST_ACK_ALO. ST_WDATA and ST_ACK_DAT alternate for each data byte. ST_TXDATA and ST_RXACK alternate for each read byte.

These transitions apply in every state:
- A Start goes to ST_DEVSEL.
- A Stop goes to ST_IDLE.
- Busy goes to ST_IDLE.

A select mismatch leaves ST_DEVSEL for ST_IDLE. A master NACK leaves ST_RXACK for ST_IDLE.

Top module: `ee_i2c_slave`

## Requirements
- R1: After reset, sda_oe, wr_stb, wr_commit and rd_en are low, and the internal address counter is 0, so a first current-address read returns the byte at address 0.
- R2: The select byte is received MSB first. Bits 7..4 must be 1010b, bits 3..1 must equal ce_pins[2:0], and bit 0 is RW (1 = read, 0 = write). SDA is driven low in the ninth slot only on a full match. Otherwise the engine releases SDA and stays silent until the next Start.
- R3: After a write select, two address bytes follow, high byte first, and each is acknowledged. The address used is {high[4:0], low[7:0]}, so high-byte bits 7..5 are ignored.
- R4: Each write data byte is acknowledged and presented as a one-cycle wr_stb pulse with wr_addr set to its address and wr_data set to its value.
- R5: Within one write transfer, the address advances after each data byte in bits 4..0 only, wrapping inside its 32-byte row.
- R6: wr_commit pulses once when a Stop arrives in the slot directly after a data byte's acknowledge. A Stop during a data byte, or a Stop before any data byte, produces no commit.
- R7: A random-address read (write select, two address bytes, repeated Start, read select) returns the byte at the sent address, MSB first.
- R8: A current-address read (a read select alone) returns the byte at the address following the last byte accessed.
- R9: During a read the address advances after each byte sent and wraps from 8191 to 0. Bytes continue while the master acknowledges. After a master NACK, SDA is released.
- R10: While busy_i is high, the engine does not acknowledge and issues no wr_stb, wr_commit or rd_en. A transaction started during busy is ignored.
- R11: A Start or repeated Start at any point restarts select reception, and a Stop at any point returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| ce_pins | input | 3 | Chip-enable straps compared with select bits 3..1 |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_stb | output | 1 | One-cycle write data strobe |
| wr_addr | output | 13 | Address of the strobed write byte |
| wr_data | output | 8 | Strobed write byte |
| wr_commit | output | 1 | Start the internal write cycle |
| rd_en | output | 1 | Read request to the memory array |
| rd_addr | output | 13 | Read address |
| rd_data | input | 8 | Memory read data, one cycle after rd_en |

## Verification
The select decoder is driven with a table of select bytes. The table varies the type nibble, the chip-enable field and the RW bit one at a time, so each compare term alone is shown to block the acknowledge. Write transfers cover three cases:
- a single byte whose high address byte carries ignored upper bits;
- a page run that crosses the end of its 32-byte row;
- a transfer cut off mid-byte.

Together these separate strobe, row-wrap and commit behaviour. Reads cover:
- a random-address read;
- a current-address read, which shows that the counter kept the previous position;
- a sequential read across the top of the array.

A repeated Start inside an address byte, and a select sent during busy, probe the framing-reset and ignore paths.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_AHI,
        ST_ADDR_LO,
        ST_ACK_ALO,
        ST_WDATA,
        ST_ACK_DAT,
        ST_TXDATA,
        ST_RXACK
    } ee_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Idle bus is high on both lines, so the chains reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_o     = scl_ff[STAGES-1];
    assign sda_o     = sda_ff[STAGES-1];
    assign scl_rise  = scl_o & ~scl_q;
    assign scl_fall  = ~scl_o & scl_q;
    // Data edges while the clock line stays high mark bus conditions.
    assign start_det = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_det  = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int AW = 13,
    parameter int PB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] addr
);

    localparam logic [PB-1:0] ROW_ONE = PB'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_full) begin
            addr <= addr + 1'b1;
        end else if (inc_page) begin
            addr <= {addr[AW-1:PB], addr[PB-1:0] + ROW_ONE};
        end
    end

    // R5: a write step never leaves its row
    a_r5_row_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load && !inc_full) |=> (addr[AW-1:PB] == $past(addr[AW-1:PB])));

    // R9: a read step from the last location lands on zero
    a_r9_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !load && (addr == {AW{1'b1}})) |=> (addr == '0));

endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
    import ee_i2c_pkg::*;
#(
    parameter int AW = 13,
    parameter int PB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    ce_pins,
    input  logic          busy_i,
    output logic          sda_oe,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_commit,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);

    localparam int          HI_W     = AW - 8;
    localparam logic [3:0]  BYTE_END = 4'd8;
    localparam logic [3:0]  SLOT_TEN = 4'd1;

    ee_state_e     state, state_d;
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg;
    logic [7:0]    tx_sh;
    logic [7:0]    rd_buf;
    logic          rd_cap;
    logic          rw_q;
    logic [HI_W-1:0] hi_q;
    logic          have_data;
    logic          sel_ok;
    logic          rx_state;
    logic          ld_addr, inc_page, inc_full;
    logic [AW-1:0] addr;

    ee_bus_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign ld_addr  = !busy_i && (state == ST_ADDR_LO) && (state_d == ST_ACK_ALO);
    assign inc_page = !busy_i && (state == ST_WDATA) && (state_d == ST_ACK_DAT);
    assign inc_full = !busy_i && (state_d == ST_TXDATA) && (state != ST_TXDATA);

    ee_addr_ctr #(.AW(AW), .PB(PB)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val ({hi_q, shreg}),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .addr     (addr)
    );

    assign rd_addr  = addr;
    assign sel_ok   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == ce_pins);
    assign rx_state = (state == ST_DEVSEL) || (state == ST_ADDR_HI) ||
                      (state == ST_ADDR_LO) || (state == ST_WDATA);

    // Next-state logic
    always_comb begin
        state_d = state;
        if (busy_i) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVSEL;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEVSEL:  if (scl_fall && bit_cnt == BYTE_END)
                                state_d = sel_ok ? ST_ACK_DEV : ST_IDLE;
                ST_ACK_DEV: if (scl_fall) state_d = rw_q ? ST_TXDATA : ST_ADDR_HI;
                ST_ADDR_HI: if (scl_fall && bit_cnt == BYTE_END) state_d = ST_ACK_AHI;
                ST_ACK_AHI: if (scl_fall) state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (scl_fall && bit_cnt == BYTE_END) state_d = ST_ACK_ALO;
                ST_ACK_ALO: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:   if (scl_fall && bit_cnt == BYTE_END) state_d = ST_ACK_DAT;
                ST_ACK_DAT: if (scl_fall) state_d = ST_WDATA;
                ST_TXDATA:  if (scl_fall && bit_cnt == BYTE_END) state_d = ST_RXACK;
                ST_RXACK: begin
                    if (scl_rise && sda_s) state_d = ST_IDLE;
                    else if (scl_fall)     state_d = ST_TXDATA;
                end
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Datapath and registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_sh     <= '0;
            rd_buf    <= '0;
            rd_cap    <= 1'b0;
            rw_q      <= 1'b0;
            hi_q      <= '0;
            have_data <= 1'b0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            rd_en     <= 1'b0;
        end else begin
            wr_stb    <= 1'b0;
            wr_commit <= 1'b0;
            rd_en     <= 1'b0;
            rd_cap    <= rd_en;
            if (rd_cap) rd_buf <= rd_data;

            if (start_det || state_d != state)
                bit_cnt <= '0;
            else if (scl_rise && (rx_state || state == ST_TXDATA))
                bit_cnt <= bit_cnt + 1'b1;

            if (scl_rise && rx_state) shreg <= {shreg[6:0], sda_s};
            if (start_det) have_data <= 1'b0;

            if (!busy_i) begin
                if (state == ST_DEVSEL && state_d == ST_ACK_DEV) begin
                    rw_q  <= shreg[0];
                    rd_en <= shreg[0];
                end
                if (state == ST_ADDR_HI && state_d == ST_ACK_AHI)
                    hi_q <= shreg[HI_W-1:0];
                if (inc_page) begin
                    wr_stb    <= 1'b1;
                    wr_addr   <= addr;
                    wr_data   <= shreg;
                    have_data <= 1'b1;
                end
                if (state == ST_RXACK && state_d == ST_RXACK && scl_rise && !sda_s)
                    rd_en <= 1'b1;
                if (stop_det && state == ST_WDATA && bit_cnt == SLOT_TEN && have_data)
                    wr_commit <= 1'b1;
                if (inc_full)
                    tx_sh <= rd_buf;
                else if (state == ST_TXDATA && state_d == ST_TXDATA && scl_fall)
                    tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ACK_DEV, ST_ACK_AHI, ST_ACK_ALO, ST_ACK_DAT: sda_oe = 1'b1;
            ST_TXDATA: sda_oe = ~tx_sh[7];
            default:   sda_oe = 1'b0;
        endcase
    end

    // R10: one cycle into busy the engine is silent
    a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> (!sda_oe && !wr_stb && !wr_commit && !rd_en));

    // R11: a Start from the bus restarts select reception
    a_r11_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy_i) |=> (state == ST_DEVSEL));

    // R11: a Stop from the bus returns to idle
    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R4: write strobe lasts one cycle
    a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R6: commit never coincides with a data strobe
    a_r6_commit_alone: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> !wr_stb);

endmodule

// File: tb/ee_i2c_slave_tb.sv
`timescale 1ns/1ps
module ee_i2c_slave_tb;

    localparam int H        = 16;
    localparam int BUSY_CYC = 2000;
    // {select byte, expected ack} with ce_pins = 3'b101
    localparam logic [8:0] SEL_VEC [6] = '{
        {8'hAA, 1'b1}, {8'hA8, 1'b0}, {8'hBA, 1'b0},
        {8'h2A, 1'b0}, {8'hAB, 1'b1}, {8'hA2, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe, wr_stb, wr_commit, rd_en;
    logic [12:0] wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data = 8'h00;
    wire         sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    int stb_cnt = 0;
    int commit_cnt = 0;
    int busy_cnt = 0;
    int pn = 0;
    logic [12:0] pa [64];
    logic [7:0]  pd [64];
    logic [12:0] log_addr [64];
    logic [7:0]  mem [8192];

    always #2.5 clk = ~clk;

    ee_i2c_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .ce_pins   (3'b101),
        .busy_i    (busy),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h3C;
    endfunction

    // memory array model
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // page write controller model
    always @(posedge clk) begin
        if (wr_stb && pn < 64) begin
            pa[pn] <= wr_addr;
            pd[pn] <= wr_data;
            log_addr[stb_cnt % 64] <= wr_addr;
            pn <= pn + 1;
            stb_cnt <= stb_cnt + 1;
        end
        if (wr_commit) begin
            for (int i = 0; i < pn; i++) mem[pa[i]] <= pd[i];
            pn <= 0;
            commit_cnt <= commit_cnt + 1;
            busy_cnt <= BUSY_CYC;
            busy <= 1'b1;
        end else if (busy_cnt > 1) begin
            busy_cnt <= busy_cnt - 1;
        end else begin
            busy_cnt <= 0;
            busy <= 1'b0;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        ack = (sda_bus == 1'b0);
        wt(H/2);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic get_byte(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl_m = 1'b1; wt(H/2);
            b[i] = sda_bus;
            wt(H/2);
            scl_m = 1'b0;
        end
        wt(H/4);
        sda_m = ~mack; wt(H);
        scl_m = 1'b1;  wt(H);
        scl_m = 1'b0;  wt(H/4);
        sda_m = 1'b1;  wt(H);
    endtask

    task automatic wait_idle();
        while (busy) wt(1);
        wt(H);
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
        logic ack;
        bus_start();
        put_byte(8'hAA, ack); chk({tag, " select ack"}, ack, 1);
        put_byte(hi, ack);    chk({tag, " high addr ack"}, ack, 1);
        put_byte(lo, ack);    chk({tag, " low addr ack"}, ack, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        int s0, c0;
        for (int i = 0; i < 8192; i++) mem[i] = pat(i);
        wt(10);
        rst_n = 1'b1;
        wt(5);

        // R1: reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 wr_stb", wr_stb, 0);
        chk("R1 wr_commit", wr_commit, 0);
        chk("R1 rd_en", rd_en, 0);
        // R1: first current-address read comes from address 0
        bus_start();
        put_byte(8'hAB, ack); chk("R1 read select ack", ack, 1);
        get_byte(d, 1'b0);    chk("R1 first byte from addr 0", d, pat(0));
        bus_stop();

        // R2: select byte table
        for (int v = 0; v < 6; v++) begin
            bus_start();
            put_byte(SEL_VEC[v][8:1], ack);
            chk($sformatf("R2 select %0h ack", SEL_VEC[v][8:1]), ack, SEL_VEC[v][0]);
            if (ack && SEL_VEC[v][1]) get_byte(d, 1'b0);
            bus_stop();
        end
        chk("R6 no commit without data", commit_cnt, 0);

        // R3, R4, R6: byte write, high-byte bits 7..5 ignored
        set_addr(8'hF2, 8'h34, "R3");
        put_byte(8'hA5, ack); chk("R4 data ack", ack, 1);
        bus_stop();
        wt(4);
        chk("R4 one strobe", stb_cnt, 1);
        chk("R3 strobe address", log_addr[0], 13'h1234);
        chk("R4 strobe data", wr_data, 8'hA5);
        chk("R6 commit after data", commit_cnt, 1);

        // R10: select during internal write is ignored
        chk("R10 busy active", busy, 1);
        bus_start();
        put_byte(8'hAA, ack); chk("R10 no ack while busy", ack, 0);
        put_byte(8'h00, ack); chk("R10 no addr ack while busy", ack, 0);
        bus_stop();
        chk("R10 no strobe while busy", stb_cnt, 1);
        wait_idle();

        // R7: random-address read
        set_addr(8'h12, 8'h34, "R7");
        bus_start();
        put_byte(8'hAB, ack); chk("R7 read select ack", ack, 1);
        get_byte(d, 1'b0);    chk("R7 random read data", d, 8'hA5);
        bus_stop();

        // R8: current-address read continues at next location
        bus_start();
        put_byte(8'hAB, ack); chk("R8 read select ack", ack, 1);
        get_byte(d, 1'b0);    chk("R8 current read data", d, pat(13'h1235));
        bus_stop();

        // R5: page write across row end
        set_addr(8'h00, 8'h5E, "R5");
        put_byte(8'h11, ack);
        put_byte(8'h22, ack);
        put_byte(8'h33, ack); chk("R5 third data ack", ack, 1);
        bus_stop();
        wt(4);
        chk("R5 first address", log_addr[1], 13'h005E);
        chk("R5 second address", log_addr[2], 13'h005F);
        chk("R5 row wrap address", log_addr[3], 13'h0040);
        chk("R6 page commit", commit_cnt, 2);
        wait_idle();
        set_addr(8'h00, 8'h40, "R5");
        bus_start();
        put_byte(8'hAB, ack);
        get_byte(d, 1'b0);    chk("R5 wrapped byte stored", d, 8'h33);
        bus_stop();

        // R9: sequential read across the top of the array
        set_addr(8'h1F, 8'hFE, "R9");
        bus_start();
        put_byte(8'hAB, ack); chk("R9 read select ack", ack, 1);
        get_byte(d, 1'b1);    chk("R9 byte at 1FFE", d, pat(13'h1FFE));
        get_byte(d, 1'b1);    chk("R9 byte at 1FFF", d, pat(13'h1FFF));
        get_byte(d, 1'b0);    chk("R9 wrapped byte at 0", d, pat(0));
        chk("R9 released after nack", sda_oe, 0);
        bus_stop();

        // R6: Stop in the middle of a data byte
        s0 = stb_cnt; c0 = commit_cnt;
        set_addr(8'h01, 8'h00, "R6");
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        wt(4);
        chk("R6 no strobe mid-byte", stb_cnt, s0);
        chk("R6 no commit mid-byte", commit_cnt, c0);
        chk("R10 not busy after abort", busy, 0);

        // R11: repeated Start inside an address byte
        bus_start();
        put_byte(8'hAA, ack); chk("R11 select ack", ack, 1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(8'hAB, ack); chk("R11 ack after restart", ack, 1);
        get_byte(d, 1'b0);    chk("R11 read keeps loaded address", d, pat(13'h0100));
        bus_stop();
        chk("R11 idle after stop", sda_oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule